// File: doc/BRIEF.md
# Serial OSD Command Decoder

This block receives 8-bit words over a three-wire synchronous serial link (an active-low select, a shift clock and a data line). It turns them into the actions of an on-screen display controller: it keeps a character-memory write address, sends character writes to the memory side, loads six control registers, runs a blank-fill sweep over every cell, and handles a command-driven soft reset. All serial inputs are brought into the system clock domain through synchronizer stages, so the shift clock must be several times slower than `clk`.

A word with bit 7 set is a command word. Bits 6..4 give a command number from 0 to 7 and bits 3..0 give parameters. A word with bit 7 clear is a data word. It applies to the last command received. Command 0 positions the cursor. Command 1 enters character-write mode, which stays active until select goes high. Commands 2 to 7 load control registers, and command 4's command word also starts the fill sweep and the soft reset.

Character writes leave through a valid/ready port. Once `wr_valid` rises, the address, code and attribute stay stable until `wr_ready` is seen high at a clock edge. The block has no queue. A character word that completes while a write is still waiting, or while the fill sweep owns the port, is discarded and the cursor does not move. The sender throttles by word spacing. The fill sweep uses the same port and waits on the same back-pressure.

Top module: `osd_cmd_decoder`

## Requirements
- R1: Bits are shifted MSB first on rising edges of `sclk` while `cs_n` is low, and a word completes on the eighth edge. A partial word is discarded when `cs_n` goes high.
- R2: A word with bit 7 = 1 sets the current command to bits 6..4. Every following word with bit 7 = 0 is applied to that same command until another command word is accepted.
- R3: For command 0, the command word's bits 3..0 set the cursor row (0 to 11) and a data word's bits 4..0 set the cursor column (0 to 23).
- R4: Command 1 latches the attribute from bit 0 of its command word. Each data word then issues one write of code bits 6..0 at the cursor. The column then advances by one, wrapping from 23 to column 0 of the next row, and from row 11 to row 0.
- R5: After command 1, words with bit 7 = 1 are neither taken as commands nor written until `cs_n` goes high.
- R6: `cs_n` high returns the current command to command 0 and leaves character-write mode.
- R7: For command n in 2..7, control slot n-2 (bits [(n-2)*11 +: 11] of `ctrl_regs`) holds {command-word bits 3..0, last data-word bits 6..0}.
- R8: `wr_valid` and the write fields stay stable while `wr_ready` is low. A character word arriving while a write is pending is dropped and the cursor does not advance.
- R9: A command-4 word with bit 2 = 1 starts a sweep that writes code 7F hex with attribute 0 to all 288 cells, in row-major order from (0,0) to (11,23). `erase_busy` is high and `disp_on` is low during the sweep.
- R10: A command-4 word with bit 0 = 1 clears every control slot, the cursor and the attribute, and forces `disp_on` low. The slots are held at zero until `cs_n` goes high.
- R11: Reset clears all control slots, the cursor and `wr_valid`. `disp_on` follows bit 0 of slot 2 when no sweep and no soft reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| sdin | input | 1 | Serial data |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_valid | output | 1 | A character write is offered |
| wr_row | output | 4 | Write row |
| wr_col | output | 5 | Write column |
| wr_code | output | 7 | Character code |
| wr_attr | output | 1 | Character attribute |
| erase_busy | output | 1 | Fill sweep in progress |
| disp_on | output | 1 | Effective display enable |
| ctrl_regs | output | 66 | Six 11-bit control slots |

## Verification
The assertions assume that `cs_n`, `sclk` and `sdin` change at least a few system clocks apart. This ensures that every serial edge is seen once after synchronization. They also assume that a fill sweep is not ordered while the soft reset is active. The stimulus holds each serial level for four clocks, changes data only while `sclk` is low, and keeps cursor values inside the 12-by-24 grid. Back-pressure is applied only in a dedicated stall scenario, and ready is driven away from the sampling edge.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int WORD_W     = 8;
  localparam int CODE_W     = 7;
  localparam int NUM_SLOT   = 6;
  localparam int FIRST_CTRL = 2;
  localparam int NIB_W      = 4;
  localparam int SLOT_W     = NIB_W + CODE_W;
  localparam int CTRL_W     = NUM_SLOT * SLOT_W;
  localparam int DSP_SLOT   = 4 - FIRST_CTRL;
  localparam logic [CODE_W-1:0] BLANK_CODE = 7'h7F;

  typedef enum logic [2:0] {
    CMD_ADDR = 3'd0,
    CMD_CHAR = 3'd1,
    CMD_DISP = 3'd4
  } cmd_e;
endpackage

// File: rtl/osd_serial_rx.sv
module osd_serial_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdin,
  output logic       cs_hi,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  localparam int CNT_W = $clog2(osd_pkg::WORD_W);

  logic [SYNC_STAGES-1:0] s_cs, s_ck, s_d;
  logic             ck_prev;
  logic [CNT_W-1:0] bit_cnt;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs    <= '1;
      s_ck    <= '0;
      s_d     <= '0;
      ck_prev <= 1'b0;
    end else begin
      s_cs    <= {s_cs[SYNC_STAGES-2:0], cs_n};
      s_ck    <= {s_ck[SYNC_STAGES-2:0], sclk};
      s_d     <= {s_d[SYNC_STAGES-2:0], sdin};
      ck_prev <= s_ck[SYNC_STAGES-1];
    end
  end

  assign cs_hi = s_cs[SYNC_STAGES-1];
  assign rise  = s_ck[SYNC_STAGES-1] & ~ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else if (cs_hi) begin
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
    end else if (rise) begin
      byte_dat <= {byte_dat[6:0], s_d[SYNC_STAGES-1]};
      bit_cnt  <= bit_cnt + 1'b1;
      byte_vld <= (bit_cnt == CNT_W'(osd_pkg::WORD_W - 1));
    end else begin
      byte_vld <= 1'b0;
    end
  end

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (bit_cnt == '0) && !byte_vld); // R1
endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq #(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  input  logic             ready,
  output logic             busy,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      row   <= '0;
      col   <= '0;
    end else begin
      if (start && !busy) armed <= 1'b1;
      if (armed && !busy && !hold) begin
        armed <= 1'b0;
        busy  <= 1'b1;
        row   <= '0;
        col   <= '0;
      end else if (busy && ready) begin
        if (col == COL_W'(COLS - 1)) begin
          col <= '0;
          if (row == ROW_W'(ROWS - 1)) begin
            row  <= '0;
            busy <= 1'b0;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  AST_ERASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (row < ROW_W'(ROWS)) && (col < COL_W'(COLS))); // R9
endmodule

// File: rtl/osd_cmd_decode.sv
module osd_cmd_decode #(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_hi,
  input  logic                         byte_vld,
  input  logic [7:0]                   byte_dat,
  input  logic                         erasing,
  input  logic                         ch_ready,
  output logic                         ch_valid,
  output logic [ROW_W-1:0]             ch_row,
  output logic [COL_W-1:0]             ch_col,
  output logic [osd_pkg::CODE_W-1:0]   ch_code,
  output logic                         ch_attr,
  output logic                         erase_go,
  output logic                         sw_rst,
  output logic [osd_pkg::CTRL_W-1:0]   ctrl_flat
);
  import osd_pkg::*;

  logic [2:0]        cmd;
  logic              lock;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              attr;
  logic [SLOT_W-1:0] slot [NUM_SLOT];
  logic [2:0]        new_idx, cur_idx;

  assign new_idx = byte_dat[6:4] - 3'(FIRST_CTRL);
  assign cur_idx = cmd - 3'(FIRST_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= CMD_ADDR;
      lock     <= 1'b0;
      row      <= '0;
      col      <= '0;
      attr     <= 1'b0;
      sw_rst   <= 1'b0;
      erase_go <= 1'b0;
      ch_valid <= 1'b0;
      ch_row   <= '0;
      ch_col   <= '0;
      ch_code  <= '0;
      ch_attr  <= 1'b0;
      for (int k = 0; k < NUM_SLOT; k++) slot[k] <= '0;
    end else begin
      erase_go <= 1'b0;
      if (ch_valid && ch_ready) ch_valid <= 1'b0;
      if (cs_hi) begin
        cmd    <= CMD_ADDR;
        lock   <= 1'b0;
        sw_rst <= 1'b0;
      end else if (byte_vld) begin
        if (byte_dat[7]) begin
          if (!lock) begin
            cmd <= byte_dat[6:4];
            case (byte_dat[6:4])
              CMD_ADDR: row <= byte_dat[ROW_W-1:0];
              CMD_CHAR: begin
                attr <= byte_dat[0];
                lock <= 1'b1;
              end
              default: begin
                slot[new_idx][SLOT_W-1:CODE_W] <= byte_dat[NIB_W-1:0];
                if (byte_dat[6:4] == CMD_DISP) begin
                  if (byte_dat[0]) sw_rst <= 1'b1;
                  if (byte_dat[2]) erase_go <= 1'b1;
                end
              end
            endcase
          end
        end else begin
          case (cmd)
            CMD_ADDR: col <= byte_dat[COL_W-1:0];
            CMD_CHAR: begin
              if ((!ch_valid || ch_ready) && !erasing) begin
                ch_valid <= 1'b1;
                ch_row   <= row;
                ch_col   <= col;
                ch_code  <= byte_dat[CODE_W-1:0];
                ch_attr  <= attr;
                if (col == COL_W'(COLS - 1)) begin
                  col <= '0;
                  row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
                end else begin
                  col <= col + 1'b1;
                end
              end
            end
            default: slot[cur_idx][CODE_W-1:0] <= byte_dat[CODE_W-1:0];
          endcase
        end
      end
      if (sw_rst) begin
        for (int k = 0; k < NUM_SLOT; k++) slot[k] <= '0;
        row  <= '0;
        col  <= '0;
        attr <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_flat
    assign ctrl_flat[g*SLOT_W +: SLOT_W] = slot[g];
  end

  AST_CS_CMD0: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (cmd == CMD_ADDR) && !lock); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cs_hi) |=> (cmd == CMD_CHAR)); // R5
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctrl_flat == '0)); // R10
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder #(
  parameter int ROWS        = 12,
  parameter int COLS        = 24,
  parameter int SYNC_STAGES = 2,
  parameter int ROW_W       = $clog2(ROWS),
  parameter int COL_W       = $clog2(COLS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdin,
  input  logic                       wr_ready,
  output logic                       wr_valid,
  output logic [ROW_W-1:0]           wr_row,
  output logic [COL_W-1:0]           wr_col,
  output logic [osd_pkg::CODE_W-1:0] wr_code,
  output logic                       wr_attr,
  output logic                       erase_busy,
  output logic                       disp_on,
  output logic [osd_pkg::CTRL_W-1:0] ctrl_regs
);
  import osd_pkg::*;
  localparam int DSP_BIT = DSP_SLOT * SLOT_W;

  logic              cs_hi, byte_vld, erase_go, sw_rst;
  logic [7:0]        byte_dat;
  logic              ch_valid, ch_attr;
  logic [ROW_W-1:0]  ch_row, er_row;
  logic [COL_W-1:0]  ch_col, er_col;
  logic [CODE_W-1:0] ch_code;

  osd_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .cs_hi(cs_hi), .byte_vld(byte_vld), .byte_dat(byte_dat));

  osd_cmd_decode #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .erasing(erase_busy), .ch_ready(wr_ready & ~erase_busy),
    .ch_valid(ch_valid), .ch_row(ch_row), .ch_col(ch_col), .ch_code(ch_code),
    .ch_attr(ch_attr), .erase_go(erase_go), .sw_rst(sw_rst), .ctrl_flat(ctrl_regs));

  osd_erase_seq #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(erase_go), .hold(ch_valid),
    .ready(wr_ready), .busy(erase_busy), .row(er_row), .col(er_col));

  always_comb begin
    if (erase_busy) begin
      wr_valid = 1'b1;
      wr_row   = er_row;
      wr_col   = er_col;
      wr_code  = BLANK_CODE;
      wr_attr  = 1'b0;
    end else begin
      wr_valid = ch_valid;
      wr_row   = ch_row;
      wr_col   = ch_col;
      wr_code  = ch_code;
      wr_attr  = ch_attr;
    end
  end

  assign disp_on = ctrl_regs[DSP_BIT] & ~erase_busy & ~sw_rst;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable({wr_row, wr_col, wr_code, wr_attr})); // R8
endmodule

// File: tb/osd_cmd_decoder_tb.sv
module osd_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdin = 0, wr_ready = 1;
  logic wr_valid, wr_attr, erase_busy, disp_on;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [6:0] wr_code;
  logic [65:0] ctrl_regs;

  int n_chk = 0, n_bad = 0;
  int n_wr = 0;
  logic [3:0] lg_row [300];
  logic [4:0] lg_col [300];
  logic [6:0] lg_code [300];
  logic       lg_attr [300];

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_row(wr_row), .wr_col(wr_col),
    .wr_code(wr_code), .wr_attr(wr_attr), .erase_busy(erase_busy),
    .disp_on(disp_on), .ctrl_regs(ctrl_regs));

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && n_wr < 300) begin
      lg_row[n_wr] = wr_row; lg_col[n_wr] = wr_col;
      lg_code[n_wr] = wr_code; lg_attr[n_wr] = wr_attr;
      n_wr++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sdin = b[i];
      tick(HALF); sclk = 1;
      tick(HALF); sclk = 0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic sel;   cs_n = 0; tick(6); endtask
  task automatic desel; tick(6); cs_n = 1; tick(8); endtask

  task automatic check_wr(input string req, input int idx, input int r, input int c,
                          input int code, input int at);
    check({req, " row"},  32'(lg_row[idx]),  32'(r));
    check({req, " col"},  32'(lg_col[idx]),  32'(c));
    check({req, " code"}, 32'(lg_code[idx]), 32'(code));
    check({req, " attr"}, 32'(lg_attr[idx]), 32'(at));
  endtask

  task automatic t_reset;
    check("R11 wr_valid", 32'(wr_valid), 0);
    check("R11 ctrl", 32'(ctrl_regs == '0), 1);
    check("R11 disp_on", 32'(disp_on), 0);
  endtask

  task automatic t_addr_write; // R2 R3 R4
    n_wr = 0;
    sel; send(8'h85); send(8'h03); send(8'h91); send(8'h41); send(8'h42); desel;
    check("R4 count", 32'(n_wr), 2);
    check_wr("R3", 0, 5, 3, 8'h41, 1);
    check_wr("R2", 1, 5, 4, 8'h42, 1);
  endtask

  task automatic t_wrap; // R4
    n_wr = 0;
    sel; send(8'h8B); send(8'h16); send(8'h90);
    send(8'h10); send(8'h11); send(8'h12); desel;
    check("R4 count", 32'(n_wr), 3);
    check_wr("R4 a", 0, 11, 22, 8'h10, 0);
    check_wr("R4 b", 1, 11, 23, 8'h11, 0);
    check_wr("R4 wrap", 2, 0, 0, 8'h12, 0);
  endtask

  task automatic t_lock; // R5
    n_wr = 0;
    sel; send(8'h80); send(8'h00); send(8'h90);
    send(8'h20); send(8'hA5); send(8'h21); desel;
    check("R5 count", 32'(n_wr), 2);
    check_wr("R5 first", 0, 0, 0, 8'h20, 0);
    check_wr("R5 after", 1, 0, 1, 8'h21, 0);
    check("R5 slot0 untouched", 32'(ctrl_regs[10:0]), 0);
  endtask

  task automatic t_cs_cmd0; // R6 R1
    n_wr = 0;
    sel; send_bits(8'hF0, 4); desel;
    sel; send(8'h07); send(8'h90); send(8'h33); desel;
    check("R6 count", 32'(n_wr), 1);
    check_wr("R6 R1", 0, 0, 7, 8'h33, 0);
  endtask

  task automatic t_regs; // R7 R2
    sel; send(8'hA6); send(8'h15); tick(8);
    check("R7 slot0", 32'(ctrl_regs[10:0]), 32'h315);
    send(8'h2A); send(8'hF9); send(8'h7F); send(8'hC0); send(8'h01); desel;
    check("R2 slot0 sticky", 32'(ctrl_regs[10:0]), 32'h32A);
    check("R7 slot5", 32'(ctrl_regs[65:55]), 32'h4FF);
    check("R7 slot2", 32'(ctrl_regs[32:22]), 32'h001);
    check("R11 disp_on", 32'(disp_on), 1);
  endtask

  task automatic t_stall; // R8
    n_wr = 0;
    wr_ready = 0;
    sel; send(8'h82); send(8'h00); send(8'h90); send(8'h55); tick(20);
    check("R8 held valid", 32'(wr_valid), 1);
    check("R8 held code", 32'(wr_code), 32'h55);
    send(8'h56); tick(10);
    check("R8 still first", 32'(wr_code), 32'h55);
    wr_ready = 1; tick(4);
    send(8'h57); desel;
    check("R8 count", 32'(n_wr), 2);
    check_wr("R8 stalled", 0, 2, 0, 8'h55, 0);
    check_wr("R8 drop no advance", 1, 2, 1, 8'h57, 0);
  endtask

  task automatic t_erase; // R9
    int bad = 0;
    int w = 0;
    n_wr = 0;
    sel; send(8'hC4);
    while (!erase_busy && w < 50) begin tick(1); w++; end
    check("R9 busy", 32'(erase_busy), 1);
    check("R9 disp off", 32'(disp_on), 0);
    w = 0;
    while (erase_busy && w < 1000) begin tick(1); w++; end
    desel;
    check("R9 count", 32'(n_wr), 288);
    for (int i = 0; i < 288 && i < n_wr; i++)
      if (lg_code[i] !== 7'h7F || lg_attr[i] !== 1'b0 ||
          lg_row[i] !== 4'(i / 24) || lg_col[i] !== 5'(i % 24)) bad++;
    check("R9 cells", 32'(bad), 0);
    check("R9 disp back", 32'(disp_on), 1);
  endtask

  task automatic t_swrst; // R10
    sel; send(8'hC1); tick(8);
    check("R10 cleared", 32'(ctrl_regs == '0), 1);
    check("R10 disp off", 32'(disp_on), 0);
    send(8'hA0); send(8'h05); tick(8);
    check("R10 held", 32'(ctrl_regs == '0), 1);
    desel;
    sel; send(8'hA0); send(8'h05); desel;
    check("R10 released", 32'(ctrl_regs == 66'h5), 1);
  endtask

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset; t_addr_write; t_wrap; t_lock; t_cs_cmd0;
    t_regs; t_stall; t_erase; t_swrst;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule